// File: doc/BRIEF.md
# Flagged Terminal I/O Unit

This block is the input/output side of a 16-bit accumulator machine. It holds one byte that has arrived from a keyboard and one byte that is waiting for a printer. Each byte has a single-bit flag. The flag tells the terminal side and the processor side which of them currently owns the register. An interrupt-enable bit is combined with the two flags to form an interrupt request.

The processor sequencer raises an execute strobe for one cycle when an I/O instruction reaches its execute step. Alongside the strobe it presents the six operation-select bits of the instruction word. Every operation completes in that single strobe cycle. Results go back to the accumulator through a byte-load output, and a skip request tells the sequencer to step past the next instruction. The keyboard side offers bytes through a valid/ready pair. The printer side sees a valid signal while a byte is pending and answers with a done pulse.

Top module: `term_io_unit`

## Requirements
- R1: After reset, kbd_ready is 1 (input flag clear), prn_valid is 0 (output flag set), irq is 0 (interrupt enable clear) and prn_data is 0.
- R2: When kbd_valid is 1 while kbd_ready is 1 and no input-transfer is executing, the unit stores kbd_data on that edge, and kbd_ready reads 0 from the next cycle.
- R3: While the input flag is set, bytes offered on the keyboard port are refused, so the stored byte is unchanged.
- R4: Input-transfer is op_bits[5] with io_strobe. In that cycle acc_load is 1 and acc_load_data equals the stored input byte. The input flag clears on that edge.
- R5: Output-transfer is op_bits[4] with io_strobe. It copies acc_lo into prn_data on that edge and clears the output flag, so prn_valid reads 1 from the next cycle.
- R6: A prn_done pulse sets the output flag, which makes prn_valid 0. If an output-transfer executes in the same cycle, the output-transfer wins and the done pulse is ignored.
- R7: In a strobe cycle, skip_req is 1 when op_bits[3] is set and the input flag is set, or when op_bits[2] is set and the output flag is set. In all other cases skip_req is 0.
- R8: op_bits[1] with io_strobe sets the interrupt enable, and op_bits[0] with io_strobe clears it. When both are given in one strobe, the enable ends up cleared.
- R9: irq equals the interrupt enable AND (input flag OR output flag).
- R10: When io_strobe is 0, op_bits have no effect: acc_load and skip_req stay 0 and no flag, byte or enable changes because of them.
- R11: When a keyboard byte is offered in the same cycle as an input-transfer, the input-transfer is performed and the byte is refused. A byte still offered in the next cycle is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_strobe | input | 1 | Execute strobe for an I/O instruction |
| op_bits | input | 6 | Operation-select bits (see R4 to R8) |
| acc_lo | input | 8 | Accumulator low byte |
| kbd_valid | input | 1 | Keyboard byte offered |
| kbd_data | input | 8 | Keyboard byte |
| kbd_ready | output | 1 | Unit can accept a keyboard byte |
| prn_done | input | 1 | Printer finished the pending byte |
| prn_valid | output | 1 | A byte is pending for the printer |
| prn_data | output | 8 | Byte held for the printer |
| acc_load | output | 1 | Load accumulator low byte this cycle |
| acc_load_data | output | 8 | Byte to load into the accumulator |
| skip_req | output | 1 | Skip the next instruction |
| irq | output | 1 | Interrupt request |

## Verification
Several behaviours are checked by assertions on every cycle. These are the flag and register updates after a keyboard accept, an input-transfer, an output-transfer or a done pulse. The assertions also check that the stored input byte holds while its flag is set, that the enable bit follows the set and clear operations, and that nothing fires without the strobe. Some behaviours only show up in the bench's scenarios, which compare every output against a reference model of the flags. These are the priority cases where two sources compete in one cycle (keyboard load against input-transfer, done pulse against output-transfer, set against clear of the enable), the value that the accumulator receives, and the skip decisions under random mixes of operation bits.

// File: rtl/term_io_pkg.sv
package term_io_pkg;

    localparam int BYTE_W = 8;
    localparam int OP_W   = 6;

    // positions inside op_bits
    localparam int OP_INP = 5;
    localparam int OP_OUT = 4;
    localparam int OP_SKI = 3;
    localparam int OP_SKO = 2;
    localparam int OP_ION = 1;
    localparam int OP_IOF = 0;

    typedef struct packed {
        logic inp;
        logic out;
        logic ski;
        logic sko;
        logic ion;
        logic iof;
    } io_cmd_t;

    function automatic io_cmd_t decode_cmd(input logic strobe, input logic [OP_W-1:0] bits);
        io_cmd_t c;
        c.inp = strobe & bits[OP_INP];
        c.out = strobe & bits[OP_OUT];
        c.ski = strobe & bits[OP_SKI];
        c.sko = strobe & bits[OP_SKO];
        c.ion = strobe & bits[OP_ION];
        c.iof = strobe & bits[OP_IOF];
        return c;
    endfunction

endpackage

// File: rtl/tio_kbd_port.sv
module tio_kbd_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         kbd_valid,
    input  logic [W-1:0] kbd_data,
    input  logic         inp_clr,
    output logic         in_flag,
    output logic [W-1:0] in_byte
);
    logic accept;
    assign accept = kbd_valid && !in_flag && !inp_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_flag <= 1'b0;
            in_byte <= '0;
        end else if (inp_clr) begin
            in_flag <= 1'b0;
        end else if (accept) begin
            in_byte <= kbd_data;
            in_flag <= 1'b1;
        end
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (kbd_valid && !in_flag && !inp_clr) |=> (in_flag && in_byte == $past(kbd_data)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (in_flag && !inp_clr) |=> (in_flag && $stable(in_byte)));

    assert_inp_clear_R4: assert property (@(posedge clk) disable iff (rst)
        inp_clr |=> !in_flag);
endmodule

// File: rtl/tio_prn_port.sv
module tio_prn_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         out_fire,
    input  logic [W-1:0] acc_lo,
    input  logic         prn_done,
    output logic         out_flag,
    output logic [W-1:0] out_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_flag <= 1'b1;
            out_byte <= '0;
        end else if (out_fire) begin
            out_byte <= acc_lo;
            out_flag <= 1'b0;
        end else if (prn_done) begin
            out_flag <= 1'b1;
        end
    end

    assert_out_load_R5: assert property (@(posedge clk) disable iff (rst)
        out_fire |=> (!out_flag && out_byte == $past(acc_lo)));

    assert_done_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (prn_done && !out_fire) |=> out_flag);
endmodule

// File: rtl/tio_ctrl.sv
module tio_ctrl
    import term_io_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            io_strobe,
    input  logic [OP_W-1:0] op_bits,
    input  logic            in_flag,
    input  logic            out_flag,
    output io_cmd_t         cmd,
    output logic            skip_req,
    output logic            irq
);
    logic ien;

    always_comb cmd = decode_cmd(io_strobe, op_bits);

    always_ff @(posedge clk) begin
        if (rst)          ien <= 1'b0;
        else if (cmd.iof) ien <= 1'b0;
        else if (cmd.ion) ien <= 1'b1;
    end

    always_comb begin
        skip_req = (cmd.ski && in_flag) || (cmd.sko && out_flag);
        irq      = ien && (in_flag || out_flag);
    end

    assert_ien_set_R8: assert property (@(posedge clk) disable iff (rst)
        (io_strobe && op_bits[OP_ION] && !op_bits[OP_IOF]) |=> ien);

    assert_ien_clr_R8: assert property (@(posedge clk) disable iff (rst)
        (io_strobe && op_bits[OP_IOF]) |=> !ien);

    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !io_strobe |-> (!skip_req && cmd == '0));
endmodule

// File: rtl/term_io_unit.sv
module term_io_unit
    import term_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              io_strobe,
    input  logic [OP_W-1:0]   op_bits,
    input  logic [BYTE_W-1:0] acc_lo,
    input  logic              kbd_valid,
    input  logic [BYTE_W-1:0] kbd_data,
    output logic              kbd_ready,
    input  logic              prn_done,
    output logic              prn_valid,
    output logic [BYTE_W-1:0] prn_data,
    output logic              acc_load,
    output logic [BYTE_W-1:0] acc_load_data,
    output logic              skip_req,
    output logic              irq
);
    io_cmd_t           cmd;
    logic              in_flag;
    logic              out_flag;
    logic [BYTE_W-1:0] in_byte;

    tio_ctrl u_ctrl (
        .clk(clk), .rst(rst), .io_strobe(io_strobe), .op_bits(op_bits),
        .in_flag(in_flag), .out_flag(out_flag), .cmd(cmd),
        .skip_req(skip_req), .irq(irq)
    );

    tio_kbd_port #(.W(BYTE_W)) u_kbd (
        .clk(clk), .rst(rst), .kbd_valid(kbd_valid), .kbd_data(kbd_data),
        .inp_clr(cmd.inp), .in_flag(in_flag), .in_byte(in_byte)
    );

    tio_prn_port #(.W(BYTE_W)) u_prn (
        .clk(clk), .rst(rst), .out_fire(cmd.out), .acc_lo(acc_lo),
        .prn_done(prn_done), .out_flag(out_flag), .out_byte(prn_data)
    );

    assign kbd_ready     = !in_flag;
    assign prn_valid     = !out_flag;
    assign acc_load      = cmd.inp;
    assign acc_load_data = in_byte;

    assert_skip_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        skip_req |-> io_strobe);
endmodule

// File: tb/term_io_unit_bench.sv
module term_io_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_strobe = 1'b0;
    logic [5:0] op_bits = '0;
    logic [7:0] acc_lo = '0;
    logic       kbd_valid = 1'b0;
    logic [7:0] kbd_data = '0;
    logic       kbd_ready;
    logic       prn_done = 1'b0;
    logic       prn_valid;
    logic [7:0] prn_data;
    logic       acc_load;
    logic [7:0] acc_load_data;
    logic       skip_req;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model
    logic       m_fgi, m_fgo, m_ien;
    logic [7:0] m_inpr, m_outr;

    always #(CLK_PERIOD/2) clk = ~clk;

    term_io_unit u_term_io_unit (
        .clk(clk), .rst(rst), .io_strobe(io_strobe), .op_bits(op_bits),
        .acc_lo(acc_lo), .kbd_valid(kbd_valid), .kbd_data(kbd_data),
        .kbd_ready(kbd_ready), .prn_done(prn_done), .prn_valid(prn_valid),
        .prn_data(prn_data), .acc_load(acc_load), .acc_load_data(acc_load_data),
        .skip_req(skip_req), .irq(irq)
    );

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_skip(input logic s, input logic [5:0] op);
        return s && ((op[3] && m_fgi) || (op[2] && m_fgo));
    endfunction

    function automatic logic exp_irq();
        return m_ien && (m_fgi || m_fgo);
    endfunction

    // one cycle: drive, check combinational outputs, update model, advance
    task automatic step(input logic s, input logic [5:0] op, input logic [7:0] acc,
                        input logic kv, input logic [7:0] kd, input logic done);
        logic inp, out;
        io_strobe = s; op_bits = op; acc_lo = acc;
        kbd_valid = kv; kbd_data = kd; prn_done = done;
        #1;
        inp = s && op[5];
        out = s && op[4];
        check("R2", "kbd_ready", {7'b0, kbd_ready}, {7'b0, !m_fgi});
        check("R6", "prn_valid", {7'b0, prn_valid}, {7'b0, !m_fgo});
        check("R5", "prn_data", prn_data, m_outr);
        check("R9", "irq", {7'b0, irq}, {7'b0, exp_irq()});
        check(s ? "R7" : "R10", "skip_req", {7'b0, skip_req}, {7'b0, exp_skip(s, op)});
        check(s ? "R4" : "R10", "acc_load", {7'b0, acc_load}, {7'b0, inp});
        if (inp) check("R4", "acc_load_data", acc_load_data, m_inpr);
        if (inp) m_fgi = 1'b0;
        else if (kv && !m_fgi) begin m_inpr = kd; m_fgi = 1'b1; end
        if (out) begin m_outr = acc; m_fgo = 1'b0; end
        else if (done) m_fgo = 1'b1;
        if (s && op[0]) m_ien = 1'b0;
        else if (s && op[1]) m_ien = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        m_fgi = 0; m_fgo = 1; m_ien = 0; m_inpr = 0; m_outr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1", "kbd_ready", {7'b0, kbd_ready}, 8'd1);
        check("R1", "prn_valid", {7'b0, prn_valid}, 8'd0);
        check("R1", "irq", {7'b0, irq}, 8'd0);
        check("R1", "prn_data", prn_data, 8'd0);
        @(negedge clk);

        // R2 accept, R3 refuse while full, R4 read
        step(0, 6'b0, 8'h00, 1, 8'hA5, 0);
        step(0, 6'b0, 8'h00, 1, 8'h5A, 0);   // R3: refused
        step(1, 6'b100000, 8'h00, 0, 8'h00, 0); // reads A5
        // R11: load collides with input-transfer
        step(0, 6'b0, 8'h00, 1, 8'h11, 0);
        step(1, 6'b100000, 8'h00, 1, 8'h22, 0); // INP wins, 22 refused
        step(0, 6'b0, 8'h00, 1, 8'h33, 0);      // R11: accepted next cycle
        step(1, 6'b101000, 8'h00, 0, 8'h00, 0); // SKI + INP, expect 33
        // R5 output, R6 done vs out collision
        step(1, 6'b010000, 8'hC3, 0, 8'h00, 0);
        step(1, 6'b010100, 8'h3C, 0, 8'h00, 1); // R6: done ignored, SKO sees 0
        step(0, 6'b0, 8'h00, 0, 8'h00, 1);
        // R8: enable set, both set+clear, irq
        step(1, 6'b000010, 8'h00, 0, 8'h00, 0);
        step(0, 6'b0, 8'h00, 0, 8'h00, 0);
        step(1, 6'b000011, 8'h00, 0, 8'h00, 0);
        step(0, 6'b0, 8'h00, 0, 8'h00, 0);
        // R10: all bits without strobe
        step(0, 6'b111111, 8'hFF, 0, 8'h00, 0);
        step(0, 6'b0, 8'h00, 0, 8'h00, 0);

        for (int i = 0; i < 3000; i++) begin
            logic       s;
            logic [5:0] op;
            s  = ($urandom % 3) != 0;
            op = ($urandom % 4 == 0) ? 6'($urandom) : 6'(1 << ($urandom % 6));
            step(s, op, 8'($urandom), ($urandom % 2) == 1, 8'($urandom), ($urandom % 4) == 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule